// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's complement operands of `W` bits and returns the full `2W`-bit signed product. It recodes the multiplier two bits at a time: each group of three overlapping multiplier bits selects one multiple of the multiplicand (zero, plus or minus once, or plus or minus twice). This gives `W/2` partial-product rows instead of `W`. The rows are sign-extended and weighted by their group position. A carry-save tree of 3:2 compressors reduces them, together with one row of carry-in bits for the negated multiples, to a sum row and a carry row. A single carry-propagate addition then forms the result.

All of the arithmetic is combinational between the operand inputs and one output register. A new operand pair can be presented every clock cycle, and each product appears one cycle later. `W` must be even; an odd or too-small width stops elaboration.

Top module: `booth4_mult`

## Requirements
- R1: At each rising clock edge where `rst` is low, `product` is loaded with the exact signed product of `mcand` and `mplr` as seen at that edge, so it is valid one cycle after the operands are presented.
- R2: At each rising edge where `rst` is high, `product` is loaded with zero, whatever the operands are.
- R3: The multiplier is split into `W/2` groups. Group i inspects the triplet (bit 2i+1, bit 2i, bit 2i-1) of `mplr`, with a 0 standing in for the bit below bit 0.
- R4: A triplet selects its multiple as follows: 000 and 111 give zero; 001 and 010 give +M; 011 gives +2M; 100 gives -2M; 101 and 110 give -M, where M is `mcand`.
- R5: A doubled multiple is the multiplicand shifted left by one bit, held in W+1 bits. The most negative operand times itself gives the positive value 2^(2W-2) with no overflow.
- R6: A negative multiple is formed as the bitwise inverse of the positive one, plus a 1 added in the tree at bit 2i of that group's row. When `mplr` is all ones, only group 0 is active, it selects -M, and `product` equals -`mcand`.
- R7: Each row is sign-extended to 2W bits and shifted left by 2i. The W/2 rows and the carry-in row are reduced by the carry-save tree to two rows whose sum, taken modulo 2^(2W), equals the product for every operand pair.
- R8: Operands may change every cycle. Each product depends only on the operands of its own capture edge, with no effect from earlier pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the product register |
| mcand | input | W | Signed multiplicand |
| mplr | input | W | Signed multiplier |
| product | output | 2W | Registered signed product |

## Verification
The only latency in the block is the output register. The product for an operand pair is therefore due exactly one rising edge after that pair is presented, and a reset clears the output at the first rising edge where `rst` is high. The bench changes operands on the falling edge and compares the output on the next falling edge against the product of the pair it applied one half-period before that rising edge. This keeps every check away from the edge and lets a new pair be applied every cycle. Two widths run side by side: every 8-bit operand pair, and random plus directed 16-bit pairs. The directed pairs cover each triplet code, an all-ones multiplier and the most-negative extremes.

// File: rtl/booth4_pkg.sv
package booth4_pkg;

  // Selection decoded from one overlapping multiplier triplet
  typedef struct packed {
    logic zero;  // multiple is 0
    logic two;   // magnitude is 2M instead of M
    logic neg;   // multiple is negated
  } booth_sel_t;

  // Triplet order: {bit 2i+1, bit 2i, bit 2i-1}
  function automatic booth_sel_t booth_recode(input logic [2:0] trip);
    booth_sel_t s;
    s = '{zero: 1'b0, two: 1'b0, neg: 1'b0};
    case (trip)
      3'b000, 3'b111: s.zero = 1'b1;
      3'b001, 3'b010: s     = '{zero: 1'b0, two: 1'b0, neg: 1'b0};
      3'b011:         s.two  = 1'b1;
      3'b100:         s      = '{zero: 1'b0, two: 1'b1, neg: 1'b1};
      default:        s.neg  = 1'b1;  // 101, 110
    endcase
    return s;
  endfunction

  // Rows left after one layer of 3:2 compression
  function automatic int rows_after_layer(input int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // Number of compression layers needed to reach two rows
  function automatic int tree_layers(input int n);
    int k;
    int m;
    k = 0;
    m = n;
    while (m > 2) begin
      m = rows_after_layer(m);
      k++;
    end
    return k;
  endfunction

endpackage

// File: rtl/booth4_recoder.sv
module booth4_recoder #(
  parameter int W = 16,
  localparam int G = W / 2
) (
  input  logic [W-1:0] mplr,
  output logic [G-1:0] zero_vec,
  output logic [G-1:0] two_vec,
  output logic [G-1:0] neg_vec
);
  import booth4_pkg::*;

  // Implied 0 below bit 0
  logic [W:0] padded;
  assign padded = {mplr, 1'b0};

  for (genvar i = 0; i < G; i++) begin : g_grp
    booth_sel_t sel;
    assign sel         = booth_recode(padded[2*i+2 -: 3]);
    assign zero_vec[i] = sel.zero;
    assign two_vec[i]  = sel.two;
    assign neg_vec[i]  = sel.neg;
  end

endmodule

// File: rtl/booth4_ppgen.sv
module booth4_ppgen #(
  parameter int W   = 16,
  parameter int ROW = 0,
  localparam int P  = 2 * W,
  localparam int SH = 2 * ROW
) (
  input  logic [W-1:0] mcand,
  input  logic         zero,
  input  logic         two,
  input  logic         neg,
  output logic [P-1:0] row
);
  logic [W:0]   mag;
  logic [W:0]   picked;
  logic [W:0]   flipped;
  logic [P-1:0] widened;

  // 2M by a one-bit shift; M sign-extended by one bit
  assign mag     = two ? {mcand, 1'b0} : {mcand[W-1], mcand};
  assign picked  = zero ? '0 : mag;
  // Inverse only; the +1 goes into the carry-in row
  assign flipped = neg ? ~picked : picked;
  assign widened = {{(P-W-1){flipped[W]}}, flipped};
  assign row     = widened << SH;

endmodule

// File: rtl/booth4_csa_tree.sv
module booth4_csa_tree #(
  parameter int P    = 32,
  parameter int ROWS = 9
) (
  input  logic [P-1:0] rows_in [ROWS],
  output logic [P-1:0] sum_o,
  output logic [P-1:0] carry_o
);
  import booth4_pkg::*;

  localparam int LAYERS = tree_layers(ROWS);
  localparam int GMAX   = ROWS / 3;

  logic [P-1:0] cur [ROWS];
  logic [P-1:0] nxt [ROWS];
  int           live;

  // Layer by layer, every full group of three rows becomes a sum row
  // and a shifted majority row; leftover rows pass straight down.
  always_comb begin
    for (int r = 0; r < ROWS; r++) cur[r] = rows_in[r];
    for (int r = 0; r < ROWS; r++) nxt[r] = '0;
    live = ROWS;
    for (int l = 0; l < LAYERS; l++) begin
      for (int r = 0; r < ROWS; r++) nxt[r] = '0;
      for (int g = 0; g < GMAX; g++) begin
        if (g < live / 3) begin
          nxt[2*g]   = cur[3*g] ^ cur[3*g+1] ^ cur[3*g+2];
          nxt[2*g+1] = ((cur[3*g] & cur[3*g+1]) |
                        (cur[3*g] & cur[3*g+2]) |
                        (cur[3*g+1] & cur[3*g+2])) << 1;
        end
      end
      for (int r = 0; r < 2; r++) begin
        if (r < live % 3) nxt[2*(live/3)+r] = cur[3*(live/3)+r];
      end
      for (int r = 0; r < ROWS; r++) cur[r] = nxt[r];
      live = rows_after_layer(live);
    end
  end

  assign sum_o   = cur[0];
  assign carry_o = cur[1];

endmodule

// File: rtl/booth4_mult.sv
module booth4_mult #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplr,
  output logic [2*W-1:0] product
);
  localparam int G    = W / 2;
  localparam int P    = 2 * W;
  localparam int ROWS = G + 1;

  if ((W % 2) != 0 || W < 4) begin : g_bad_width
    $error("booth4_mult: W must be even and at least 4");
  end

  logic [G-1:0] zero_vec;
  logic [G-1:0] two_vec;
  logic [G-1:0] neg_vec;
  logic [P-1:0] pp_rows [ROWS];
  logic [P-1:0] corr_row;
  logic [P-1:0] tree_sum;
  logic [P-1:0] tree_carry;
  logic [P-1:0] sum_full;

  booth4_recoder #(.W(W)) u_recode (
    .mplr     (mplr),
    .zero_vec (zero_vec),
    .two_vec  (two_vec),
    .neg_vec  (neg_vec)
  );

  for (genvar i = 0; i < G; i++) begin : g_row
    booth4_ppgen #(.W(W), .ROW(i)) u_pp (
      .mcand (mcand),
      .zero  (zero_vec[i]),
      .two   (two_vec[i]),
      .neg   (neg_vec[i]),
      .row   (pp_rows[i])
    );
  end

  // Carry-in row completing the two's complement of negated rows
  always_comb begin
    corr_row = '0;
    for (int i = 0; i < G; i++) corr_row[2*i] = neg_vec[i];
  end
  assign pp_rows[G] = corr_row;

  booth4_csa_tree #(.P(P), .ROWS(ROWS)) u_tree (
    .rows_in (pp_rows),
    .sum_o   (tree_sum),
    .carry_o (tree_carry)
  );

  assign sum_full = tree_sum + tree_carry;

  always_ff @(posedge clk) begin
    if (rst) product <= '0;
    else     product <= sum_full;
  end

endmodule

// File: rtl/booth4_mult_chk.sv
module booth4_mult_chk #(
  parameter int W = 16,
  localparam int G = W / 2,
  localparam int P = 2 * W
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] mcand,
  input logic [W-1:0] mplr,
  input logic [P-1:0] product,
  input logic [P-1:0] tree_sum,
  input logic [P-1:0] tree_carry,
  input logic [G-1:0] zero_vec,
  input logic [G-1:0] two_vec,
  input logic [G-1:0] neg_vec
);
  logic signed [P-1:0] ref_prod;
  logic        [P-1:0] tree_total;

  assign ref_prod   = $signed({{W{mcand[W-1]}}, mcand}) * $signed({{W{mplr[W-1]}}, mplr});
  assign tree_total = tree_sum + tree_carry;

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> product == $past(ref_prod));

  assert_reset_clear_R2: assert property (@(posedge clk)
    rst |=> product == '0);

  assert_zero_mplr_R4: assert property (@(posedge clk) disable iff (rst)
    mplr == '0 |-> (zero_vec == '1 && neg_vec == '0 && two_vec == '0));

  assert_minus_two_R5: assert property (@(posedge clk) disable iff (rst)
    mplr == W'(2) |-> (two_vec[0] && neg_vec[0] && !zero_vec[0]));

  assert_neg_one_R6: assert property (@(posedge clk) disable iff (rst)
    mplr == '1 |-> (neg_vec == G'(1) && zero_vec == ~G'(1) && two_vec == '0));

  assert_tree_total_R7: assert property (@(posedge clk) disable iff (rst)
    tree_total == ref_prod);

endmodule

bind booth4_mult booth4_mult_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mcand      (mcand),
  .mplr       (mplr),
  .product    (product),
  .tree_sum   (tree_sum),
  .tree_carry (tree_carry),
  .zero_vec   (zero_vec),
  .two_vec    (two_vec),
  .neg_vec    (neg_vec)
);

// File: tb/sim_booth4_mult.sv
module sim_booth4_mult;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0]  a8 = 8'h5a, b8 = 8'hc3;
  logic [15:0] a16 = 16'h1234, b16 = 16'h8765;
  logic [15:0] p8;
  logic [31:0] p16;

  booth4_mult #(.W(8))  u0 (.clk(clk), .rst(rst), .mcand(a8),  .mplr(b8),  .product(p8));
  booth4_mult #(.W(16)) u1 (.clk(clk), .rst(rst), .mcand(a16), .mplr(b16), .product(p16));

  int     checks = 0;
  int     errors = 0;
  bit     done = 1'b0;
  bit     pend = 1'b0;
  string  ptag;
  longint pexp8, pexp16;

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      check({ptag, " (w8)"},  longint'($signed(p8)),  pexp8);
      check({ptag, " (w16)"}, longint'($signed(p16)), pexp16);
    end
  endtask

  // Apply a pair on the falling edge; its product is due one rising edge later
  task automatic apply(input string tag, input logic [7:0] x8, input logic [7:0] y8,
                       input logic [15:0] x16, input logic [15:0] y16);
    @(negedge clk);
    check_pending();
    a8 = x8; b8 = y8; a16 = x16; b16 = y16;
    pexp8  = longint'($signed(x8))  * longint'($signed(y8));
    pexp16 = longint'($signed(x16)) * longint'($signed(y16));
    ptag = tag;
    pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
    pend = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", WDOG_CYCLES, WDOG_CYCLES);
      finish_run();
    end
  end

  initial begin
    // R2: reset holds product at zero despite nonzero operands
    repeat (3) @(negedge clk);
    check("R2 reset clear (w8)",  longint'(p8),  0);
    check("R2 reset clear (w16)", longint'(p16), 0);
    rst = 1'b0;

    // R3 / R4: each triplet code through low multiplier values
    apply("R4 mplr=1 code 010",          8'd23,  8'd1,   16'd1234,  16'd1);
    apply("R3 mplr=3 codes 110,001",     8'd23,  8'd3,   16'd1234,  16'd3);
    apply("R5 mplr=2 code 100 -2M",      8'd23,  8'd2,   16'd1234,  16'd2);
    apply("R4 mplr=6 codes 100,011",     8'd77,  8'd6,   16'd777,   16'd6);
    apply("R4 mplr=5 code 010 twice",    8'd77,  8'd5,   16'd777,   16'd5);
    apply("R4 mplr=10 code 101",         8'd77,  8'd10,  16'd777,   16'd10);
    apply("R3 mplr=-2 codes 100,111",    8'd99,  8'hfe,  16'd9999,  16'hfffe);
    apply("R4 mplr=0 all zero",          8'd99,  8'd0,   16'd9999,  16'd0);
    // R6: negated multiples and the all-ones multiplier
    apply("R6 mplr=-1 gives -mcand",     8'd45,  8'hff,  16'd31000, 16'hffff);
    apply("R6 mplr=-1 mcand negative",   8'h91,  8'hff,  16'h8123,  16'hffff);
    apply("R6 mcand=-1 mplr=-3",         8'hff,  8'hfd,  16'hffff,  16'hfffd);
    // R5: extremes
    apply("R5 min times min",            8'h80,  8'h80,  16'h8000,  16'h8000);
    apply("R5 min times max",            8'h80,  8'h7f,  16'h8000,  16'h7fff);
    apply("R5 max times max",            8'h7f,  8'h7f,  16'h7fff,  16'h7fff);
    apply("R5 max times min",            8'h7f,  8'h80,  16'h7fff,  16'h8000);
    // R8: alternating multiplier pattern, back to back
    apply("R8 alternating 1010",         8'h37,  8'haa,  16'h3737,  16'haaaa);
    apply("R8 alternating 0101",         8'h37,  8'h55,  16'h3737,  16'h5555);
    apply("R8 repeat pair",              8'h37,  8'h55,  16'h3737,  16'h5555);
    apply("R8 next pair",                8'hc9,  8'h2b,  16'hc9c9,  16'h2b2b);
    flush();

    // R2: mid-run reset with operands still applied
    @(negedge clk);
    a8 = 8'h7b; b8 = 8'h66; a16 = 16'h7bcd; b16 = 16'h6601;
    rst = 1'b1;
    @(negedge clk);
    check("R2 mid-run reset (w8)",  longint'(p8),  0);
    check("R2 mid-run reset (w16)", longint'(p16), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset release (w8)",  longint'($signed(p8)),  longint'($signed(8'h7b)) * longint'($signed(8'h66)));
    check("R1 after reset release (w16)", longint'($signed(p16)), longint'($signed(16'h7bcd)) * longint'($signed(16'h6601)));

    // R1 / R7: every 8-bit pair, random 16-bit pairs alongside
    for (int i = 0; i < 65536; i++) begin
      apply("R1 R7 sweep", i[15:8], i[7:0], 16'($urandom), 16'($urandom));
    end
    // R8: random pairs every cycle at both widths
    for (int i = 0; i < 3000; i++) begin
      apply("R8 random", 8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom));
    end
    flush();

    done = 1'b1;
    finish_run();
  end

endmodule